// File: doc/BRIEF.md
# Instruction Predecode Tagger

This block sits beside the fill path of an instruction cache line. While the line's bytes are written in, one byte per cycle in ascending offset order, it works out where each instruction begins. It also works out which byte holds the opcode, whether the instruction can take the simple direct decode path or needs the microcoded path, and whether it is a call, a return or a short unconditional jump. For every byte it accepts, it emits one side-band word, to be stored next to that byte in the cache.

Only a subset of encodings is length-decoded:
- legacy prefixes;
- one-byte opcodes from a fixed table;
- a ModRM byte without an index byte;
- displacements;
- 8-bit and 16/32-bit immediates.

Anything outside the table is tagged as microcoded with a length of one byte.

When a short jump lies wholly inside the line, the scan does not go on linearly. It resumes at the jump target, and the bytes in between are left untagged. A jump that points backwards, or out of the line, ends tagging for the remainder of the line.

Top module: `predecode_tagger`

## Requirements
- R1: Each accepted byte (`in_valid` high) produces exactly one write (`pd_we` high) on the next cycle, carrying the same offset. No write occurs in a cycle that follows one with `in_valid` low. Tag word layout: bit0 start, bit1 opcode, bit2 microcoded, bits4:3 branch kind, bit5 scanned.
- R2: Bit0 is set on the first byte of every tagged instruction, which is its first prefix or, when there is no prefix, its opcode. The byte at offset 0 is always a start.
- R3: Bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF2 and 0xF3 are prefixes. They carry bit5 but never bit1. Bit1 marks the first non-prefix byte of the instruction.
- R4: Length rules apply in the following order.
  - A ModRM byte adds a displacement: 4 bytes for mod=00 with rm=101, 1 byte for mod=01, 4 bytes for mod=10, and none for mod=11.
  - An 8-bit immediate adds 1 byte.
  - A full immediate adds 4 bytes, or 2 bytes when a 0x66 prefix is present.
  - The supported opcodes are:
    - 00-3F with low three bits 0-3: ModRM;
    - 00-3F with low three bits 4: imm8;
    - 00-3F with low three bits 5: full immediate;
    - 40-5F: one byte;
    - 70-7F: imm8;
    - 80 and 83: ModRM plus imm8;
    - 81: ModRM plus full immediate;
    - 88-8B: ModRM;
    - 90: one byte;
    - B0-B7: imm8;
    - B8-BF: full immediate;
    - C3: one byte;
    - E8: full immediate;
    - EB: imm8.
  - Every byte after the opcode gets only bit5.
- R5: A ModRM byte with rm=100 and mod other than 11 ends the instruction at that ModRM byte.
- R6: An opcode outside the table of R4 gets bit2 set and a length of one byte. A supported opcode has bit2 clear.
- R7: On the opcode byte, bits4:3 give the branch kind: 01 for 0xE8 (call), 10 for 0xC3 (return), 11 for 0xEB (short jump), and 00 otherwise.
- R8: For 0xEB, the target is the offset after the displacement byte plus the sign-extended displacement. If the target lies ahead and inside the line, the bytes before it are written as all-zero words, and the target byte starts a new instruction.
- R9: A zero displacement lets tagging continue at the next byte. A target behind the next byte, or at or beyond the line size, makes every remaining byte of the line an all-zero word.
- R10: A byte at offset 0 restarts tagging with fresh state, dropping any unfinished instruction, skip or stop left over from the previous line.
- R11: While `rst` is high, `pd_we` and `pd_bits` are held at zero, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fill byte present this cycle |
| in_off | input | OFFW | Offset of the byte within the line |
| in_byte | input | 8 | Instruction byte being filled |
| pd_we | output | 1 | Tag word write enable |
| pd_off | output | OFFW | Offset the tag word belongs to |
| pd_bits | output | 6 | Tag word (layout in R1) |

## Verification
Every result of this block is due exactly one cycle after the byte that causes it, because the tag word passes through a single output register. Skip and stop decisions take effect on the byte that immediately follows the jump displacement.

The bench drives each byte just after a falling edge. At the following falling edge it captures whatever write is present into a per-offset array. It then compares the whole line against hand-computed tag words once the line's last write has been collected.

One extra cycle with `in_valid` low checks that no stray write follows.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  localparam int PD_W = 6;

  typedef struct packed {
    logic       scanned;
    logic [1:0] brk;
    logic       vec;
    logic       opc;
    logic       start;
  } pd_bits_t;

  localparam logic [1:0] BRK_NONE = 2'b00;
  localparam logic [1:0] BRK_CALL = 2'b01;
  localparam logic [1:0] BRK_RET  = 2'b10;
  localparam logic [1:0] BRK_JMP  = 2'b11;

  typedef enum logic [1:0] {IMM_NONE, IMM_B, IMM_Z} imm_kind_t;

  typedef struct packed {
    logic       modrm;
    imm_kind_t  imm;
    logic       vec;
    logic [1:0] brk;
    logic       is_jmp;
  } op_info_t;

  typedef enum logic [2:0] {
    SC_OPC, SC_MODRM, SC_DISP, SC_IMM, SC_SKIP, SC_DEAD
  } scan_st_t;

  function automatic logic is_prefix(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF2, 8'hF3: is_prefix = 1'b1;
      default:                    is_prefix = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pdt_opclass.sv
module pdt_opclass
  import pdt_pkg::*;
(
  input  logic [7:0] op,
  input  logic       opsz16,
  output op_info_t   info,
  output logic [2:0] imm_len
);

  always_comb begin
    info        = '0;
    info.imm    = IMM_NONE;
    info.vec    = 1'b1;
    info.brk    = BRK_NONE;
    if (op[7:6] == 2'b00 && op[2:1] != 2'b11) begin
      info.vec = 1'b0;
      case (op[2:0])
        3'd4:    info.imm   = IMM_B;
        3'd5:    info.imm   = IMM_Z;
        default: info.modrm = 1'b1;
      endcase
    end else if (op[7:5] == 3'b010) begin
      info.vec = 1'b0;
    end else if (op[7:4] == 4'h7) begin
      info.vec = 1'b0;
      info.imm = IMM_B;
    end else if (op[7:3] == 5'b10110) begin
      info.vec = 1'b0;
      info.imm = IMM_B;
    end else if (op[7:3] == 5'b10111) begin
      info.vec = 1'b0;
      info.imm = IMM_Z;
    end else begin
      case (op)
        8'h80, 8'h83: begin
          info.vec = 1'b0; info.modrm = 1'b1; info.imm = IMM_B;
        end
        8'h81: begin
          info.vec = 1'b0; info.modrm = 1'b1; info.imm = IMM_Z;
        end
        8'h88, 8'h89, 8'h8A, 8'h8B: begin
          info.vec = 1'b0; info.modrm = 1'b1;
        end
        8'h90: info.vec = 1'b0;
        8'hC3: begin
          info.vec = 1'b0; info.brk = BRK_RET;
        end
        8'hE8: begin
          info.vec = 1'b0; info.imm = IMM_Z; info.brk = BRK_CALL;
        end
        8'hEB: begin
          info.vec = 1'b0; info.imm = IMM_B; info.brk = BRK_JMP;
          info.is_jmp = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (info.imm)
      IMM_B:   imm_len = 3'd1;
      IMM_Z:   imm_len = opsz16 ? 3'd2 : 3'd4;
      default: imm_len = 3'd0;
    endcase
  end

endmodule

// File: rtl/pdt_scan.sv
module pdt_scan
  import pdt_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int OFFW       = $clog2(LINE_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OFFW-1:0] in_off,
  input  logic [7:0]      in_byte,
  output pd_bits_t        bits
);

  localparam int TW = ((OFFW > 8) ? OFFW : 8) + 2;

  scan_st_t        st, st_n, cur;
  logic [2:0]      cnt, cnt_n, immp, immp_n;
  logic            osz, osz_n, pfx, pfx_n, jmp, jmp_n;
  logic [OFFW-1:0] res, res_n;
  logic            fresh, cur_pfx, cur_osz;
  op_info_t        info;
  logic [2:0]      imm_len;
  logic [2:0]      disp_len;
  logic            sib;
  logic signed [TW-1:0] nxt, tgt;

  assign fresh   = (in_off == '0) || (st == SC_SKIP && in_off == res);
  assign cur     = fresh ? SC_OPC : st;
  assign cur_pfx = fresh ? 1'b0 : pfx;
  assign cur_osz = fresh ? 1'b0 : osz;

  pdt_opclass u_cls (
    .op      (in_byte),
    .opsz16  (cur_osz),
    .info    (info),
    .imm_len (imm_len)
  );

  always_comb begin
    sib = (in_byte[7:6] != 2'b11) && (in_byte[2:0] == 3'b100);
    case (in_byte[7:6])
      2'b00:   disp_len = (in_byte[2:0] == 3'b101) ? 3'd4 : 3'd0;
      2'b01:   disp_len = 3'd1;
      2'b10:   disp_len = 3'd4;
      default: disp_len = 3'd0;
    endcase
    nxt = TW'(in_off) + TW'(1);
    tgt = nxt + TW'(signed'(in_byte));
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    immp_n = immp;
    osz_n  = osz;
    pfx_n  = pfx;
    jmp_n  = jmp;
    res_n  = res;
    bits   = '0;
    if (in_valid) begin
      case (cur)
        SC_OPC: begin
          bits.scanned = 1'b1;
          bits.start   = !cur_pfx;
          if (is_prefix(in_byte)) begin
            st_n  = SC_OPC;
            pfx_n = 1'b1;
            osz_n = cur_osz | (in_byte == 8'h66);
          end else begin
            bits.opc = 1'b1;
            bits.vec = info.vec;
            bits.brk = info.brk;
            pfx_n    = 1'b0;
            osz_n    = 1'b0;
            jmp_n    = info.is_jmp;
            if (info.modrm) begin
              st_n   = SC_MODRM;
              immp_n = imm_len;
            end else if (imm_len != 3'd0) begin
              st_n  = SC_IMM;
              cnt_n = imm_len;
            end else begin
              st_n = SC_OPC;
            end
          end
        end
        SC_MODRM: begin
          bits.scanned = 1'b1;
          if (sib) begin
            st_n = SC_OPC;
          end else if (disp_len != 3'd0) begin
            st_n  = SC_DISP;
            cnt_n = disp_len;
          end else if (immp != 3'd0) begin
            st_n  = SC_IMM;
            cnt_n = immp;
          end else begin
            st_n = SC_OPC;
          end
        end
        SC_DISP: begin
          bits.scanned = 1'b1;
          if (cnt == 3'd1) begin
            if (immp != 3'd0) begin
              st_n  = SC_IMM;
              cnt_n = immp;
            end else begin
              st_n = SC_OPC;
            end
          end else begin
            cnt_n = cnt - 3'd1;
          end
        end
        SC_IMM: begin
          bits.scanned = 1'b1;
          if (cnt == 3'd1) begin
            jmp_n = 1'b0;
            if (!jmp || tgt == nxt) begin
              st_n = SC_OPC;
            end else if (tgt > nxt && tgt < TW'(LINE_BYTES)) begin
              st_n  = SC_SKIP;
              res_n = tgt[OFFW-1:0];
            end else begin
              st_n = SC_DEAD;
            end
          end else begin
            cnt_n = cnt - 3'd1;
          end
        end
        default: bits = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SC_OPC;
      cnt  <= '0;
      immp <= '0;
      osz  <= 1'b0;
      pfx  <= 1'b0;
      jmp  <= 1'b0;
      res  <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      immp <= immp_n;
      osz  <= osz_n;
      pfx  <= pfx_n;
      jmp  <= jmp_n;
      res  <= res_n;
    end
  end

  // R9
  dead_holds_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SC_DEAD && in_valid && in_off != '0) |=> st == SC_DEAD);

  // R4
  imm_count_steps_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SC_IMM && in_valid && in_off != '0 && cnt > 3'd1)
      |=> (st == SC_IMM && cnt == $past(cnt) - 3'd1));

  // R8
  skip_is_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (st_n == SC_SKIP && st != SC_SKIP && in_valid) |=> res > $past(in_off));

endmodule

// File: rtl/pdt_outreg.sv
module pdt_outreg
  import pdt_pkg::*;
#(
  parameter int OFFW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OFFW-1:0] in_off,
  input  pd_bits_t        bits,
  output logic            pd_we,
  output logic [OFFW-1:0] pd_off,
  output logic [PD_W-1:0] pd_bits
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_we   <= 1'b0;
      pd_off  <= '0;
      pd_bits <= '0;
    end else begin
      pd_we   <= in_valid;
      pd_off  <= in_off;
      pd_bits <= in_valid ? bits : '0;
    end
  end

  // R1
  write_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (pd_we && pd_off == $past(in_off)));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !pd_we);

  // R2
  line_head_start_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_off == '0) |=> pd_bits[0]);

  // R7
  branch_on_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_we && pd_bits[4:3] != 2'b00) |-> pd_bits[1]);

  // R6
  vec_on_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_we && pd_bits[2]) |-> pd_bits[1]);

endmodule

// File: rtl/predecode_tagger.sv
module predecode_tagger
  import pdt_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int OFFW       = $clog2(LINE_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OFFW-1:0] in_off,
  input  logic [7:0]      in_byte,
  output logic            pd_we,
  output logic [OFFW-1:0] pd_off,
  output logic [PD_W-1:0] pd_bits
);

  pd_bits_t tag;

  pdt_scan #(.LINE_BYTES(LINE_BYTES), .OFFW(OFFW)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_off   (in_off),
    .in_byte  (in_byte),
    .bits     (tag)
  );

  pdt_outreg #(.OFFW(OFFW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_off   (in_off),
    .bits     (tag),
    .pd_we    (pd_we),
    .pd_off   (pd_off),
    .pd_bits  (pd_bits)
  );

endmodule

// File: tb/sim_predecode_tagger.sv
module sim_predecode_tagger;

  localparam int LB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_off = '0;
  logic [7:0] in_byte = '0;
  logic       pd_we;
  logic [3:0] pd_off;
  logic [5:0] pd_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] line_b [LB];
  logic [5:0] exp_b  [LB];
  logic [5:0] cap    [LB];
  bit         seen   [LB];

  always #10 clk = ~clk;

  predecode_tagger #(.LINE_BYTES(LB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_off(in_off),
    .in_byte(in_byte), .pd_we(pd_we), .pd_off(pd_off), .pd_bits(pd_bits)
  );

  task automatic check(input string tag, input int off, input logic [5:0] got,
                       input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s off %0d: got %h expected %h", tag, off, got, exp);
    end
  endtask

  task automatic put(input int i, input logic [7:0] b, input logic [5:0] e);
    line_b[i] = b;
    exp_b[i]  = e;
  endtask

  task automatic fill(input logic [7:0] b, input logic [5:0] e);
    for (int i = 0; i < LB; i++) put(i, b, e);
  endtask

  task automatic capture();
    if (pd_we) begin
      cap[pd_off]  = pd_bits;
      seen[pd_off] = 1'b1;
    end
  endtask

  task automatic send_check(input int n, input string tag);
    for (int i = 0; i < LB; i++) seen[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      capture();
      in_valid = 1'b1;
      in_off   = 4'(i);
      in_byte  = line_b[i];
    end
    @(negedge clk);
    capture();
    in_valid = 1'b0;
    @(negedge clk);
    // R1: no write after an idle cycle
    check({tag, " R1 idle"}, -1, {5'b0, pd_we}, 6'h00);
    for (int i = 0; i < n; i++) begin
      check({tag, " R1 written"}, i, {5'b0, seen[i]}, 6'h01);
      check(tag, i, cap[i], exp_b[i]);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1; in_off = 4'd0; in_byte = 8'hC3;
    repeat (3) @(negedge clk);
    // R11
    check("R11 we in reset", 0, {5'b0, pd_we}, 6'h00);
    check("R11 bits in reset", 0, pd_bits, 6'h00);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset", 0, {5'b0, pd_we}, 6'h00);
  endtask

  task automatic t_mix_a();
    put(0, 8'h66, 6'h21); put(1, 8'h05, 6'h22); put(2, 8'h34, 6'h20);
    put(3, 8'h12, 6'h20); put(4, 8'h89, 6'h23); put(5, 8'h45, 6'h20);
    put(6, 8'h08, 6'h20); put(7, 8'h81, 6'h23); put(8, 8'hC0, 6'h20);
    put(9, 8'h01, 6'h20); put(10, 8'h02, 6'h20); put(11, 8'h03, 6'h20);
    put(12, 8'h04, 6'h20); put(13, 8'hF4, 6'h27); put(14, 8'hC3, 6'h33);
    put(15, 8'h90, 6'h23);
    send_check(LB, "R2/R3/R4/R6/R7 mix_a");
  endtask

  task automatic t_mix_b();
    put(0, 8'h8B, 6'h23); put(1, 8'h04, 6'h20); put(2, 8'hE8, 6'h2B);
    put(3, 8'h10, 6'h20); put(4, 8'h00, 6'h20); put(5, 8'h00, 6'h20);
    put(6, 8'h00, 6'h20); put(7, 8'h8B, 6'h23); put(8, 8'h05, 6'h20);
    put(9, 8'h11, 6'h20); put(10, 8'h22, 6'h20); put(11, 8'h33, 6'h20);
    put(12, 8'h44, 6'h20); put(13, 8'h3E, 6'h21); put(14, 8'h90, 6'h22);
    put(15, 8'h40, 6'h23);
    send_check(LB, "R5/R4/R7 mix_b");
  endtask

  task automatic t_jump_fwd();
    fill(8'h90, 6'h23);
    put(0, 8'hEB, 6'h3B); put(1, 8'h03, 6'h20);
    put(2, 8'hAA, 6'h00); put(3, 8'hBB, 6'h00); put(4, 8'hCC, 6'h00);
    put(6, 8'hB0, 6'h23); put(7, 8'h55, 6'h20);
    send_check(LB, "R8 jump_fwd");
  endtask

  task automatic t_jump_back();
    fill(8'h90, 6'h00);
    put(0, 8'hEB, 6'h3B); put(1, 8'h00, 6'h20);
    put(2, 8'hEB, 6'h3B); put(3, 8'hFC, 6'h20);
    send_check(LB, "R9 jump_back");
  endtask

  task automatic t_jump_out();
    fill(8'h90, 6'h00);
    put(0, 8'h90, 6'h23); put(1, 8'hEB, 6'h3B); put(2, 8'h7F, 6'h20);
    send_check(LB, "R9 jump_out");
  endtask

  task automatic t_restart();
    fill(8'h90, 6'h23);
    put(15, 8'hB8, 6'h23);
    send_check(LB, "R10 line_a");
    put(0, 8'h90, 6'h23); put(1, 8'hF3, 6'h21); put(2, 8'h2E, 6'h20);
    put(3, 8'hA4, 6'h26); put(4, 8'hB8, 6'h23); put(5, 8'h01, 6'h20);
    put(6, 8'h02, 6'h20); put(7, 8'h03, 6'h20); put(8, 8'h04, 6'h20);
    put(9, 8'h66, 6'h21); put(10, 8'hB8, 6'h22); put(11, 8'h01, 6'h20);
    put(12, 8'h02, 6'h20); put(13, 8'h70, 6'h23); put(14, 8'h05, 6'h20);
    put(15, 8'hC3, 6'h33);
    send_check(LB, "R10/R3 line_b");
    fill(8'h90, 6'h00);
    put(0, 8'hEB, 6'h3B); put(1, 8'h0A, 6'h20);
    send_check(8, "R8 partial skip");
    fill(8'h90, 6'h23);
    send_check(LB, "R10 after skip");
  endtask

  initial begin
    t_reset();
    t_mix_a();
    t_mix_b();
    t_jump_fwd();
    t_jump_back();
    t_jump_out();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule